// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator

This block drives a three-phase inverter bridge. A shared 16-bit time base runs at the system clock. It counts up to the programmed half-period and then back down, so one switching cycle lasts twice the half-period value in clocks. For each phase, a comparison between that counter and the phase's duty value gives a high-side on-time centered in the cycle. The low side is the complement of the high side, with a programmed dead band removed before and after every high-side pulse. All six gate lines are active low: a low level turns the switch on.

Software programs the block through a simple write port. The writable values are the half-period, one dead-time value shared by all phases, three duty values, a sync pulse width, an update-mode bit and a trip-clear command. Written values are staged. They reach the working copies at the end of each cycle, and in double update mode also at the turnaround in the middle of the cycle. Each cycle starts with a sync pulse and a one-clock sync interrupt strobe. An external trip input forces every gate line off at once and keeps it off until software clears it. A trip also pulses a shutdown interrupt strobe.

Top module: `cpwm_top`

## Requirements
- R1: The write port maps addresses as follows, with data taken from the low bits of `wr_data`: 0 half-period P, 1 dead time DT (bits 9:0), 2, 3 and 4 the duty values of phases 0, 1 and 2, 5 sync width W (bits 7:0), 6 mode (bit 0, 1 = double update), 7 control (bit 0 = 1 clears the trip latch). A half-period of 0 is treated as 1.
- R2: Consecutive rising edges of `sync_o` are exactly 2×P clocks apart.
- R3: Take cycle index 0 as the clock in which `sync_o` rises. For a duty value D with 0 < D < P, the high-side line of that phase is low (on) for exactly 2×D clocks per cycle, starting at index P−D.
- R4: A duty value of 0 keeps the high side off and the low side on for the whole cycle. A duty value at or above P keeps the high side on and the low side off for the whole cycle.
- R5: Between the high side turning off and the low side turning on, exactly 2×DT clocks pass with both lines of the pair off. The same gap comes before the high side turns on. A pair never has both lines on.
- R6: A DT of 0 gives no off gap, so the low side turns on in the clock right after the high side turns off.
- R7: While reset is held, all six gate lines are high (off), `sync_o` is low and both strobes are low. After reset the mode is single update and every duty value is 0.
- R8: In single update mode, values written during a cycle take effect only at the start of the next cycle.
- R9: In double update mode, a duty value written during the rising half of a cycle takes effect from the falling half of that same cycle.
- R10: `sync_o` is high for W clocks from each cycle start, and `sync_irq_o` pulses for one clock at each cycle start.
- R11: A high `trip_i` drives all six gate lines high from the next clock. `trip_irq_o` pulses for one clock after each rising edge of `trip_i`. The lines stay high after `trip_i` falls until a clear command is written.
- R12: A clear command written while `trip_i` is still high has no effect: the lines stay off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one time-base tick per clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| trip_i | input | 1 | External fault input, active high |
| sync_o | output | 1 | Cycle-start sync pulse |
| sync_irq_o | output | 1 | One-clock strobe at each cycle start |
| trip_irq_o | output | 1 | One-clock strobe on a trip rising edge |
| hi_n_o | output | 3 | High-side gate lines, active low, one per phase |
| lo_n_o | output | 3 | Low-side gate lines, active low, one per phase |

## Verification
The hardest case to set up is a working-copy load in the middle of a cycle. It needs double update mode, an already settled cycle, and a duty write that lands inside the rising half and before the turnaround. The stimulus lines up with a sync rising edge and injects the write two clocks later, inside the measurement window. The first cycle then shows an asymmetric pulse: the old threshold in the rising half and the new one in the falling half. The following cycle is symmetric at the new value. The same injection is repeated in single update mode to show that nothing changes until the next cycle. Trip recovery needs a clear that is refused while the input is still high, followed by a clear that is accepted.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int CW  = 16;
  localparam int DW  = 10;
  localparam int SW  = 8;
  localparam int NPH = 3;
  localparam int AW  = 3;

  typedef enum logic [AW-1:0] {
    A_PER   = 3'd0,
    A_DT    = 3'd1,
    A_DUTY0 = 3'd2,
    A_DUTY1 = 3'd3,
    A_DUTY2 = 3'd4,
    A_SYNCW = 3'd5,
    A_MODE  = 3'd6,
    A_CTRL  = 3'd7
  } addr_e;

  typedef struct packed {
    logic [CW-1:0]          per;
    logic [DW-1:0]          dt;
    logic [NPH-1:0][CW-1:0] duty;
    logic [SW-1:0]          syncw;
  } cfg_t;
endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
  import cpwm_pkg::*;
#(
  parameter int RST_PERIOD = 16,
  parameter int RST_SYNCW  = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          ld,
  output logic          dbl,
  output logic          clr,
  output cfg_t          work
);
  cfg_t shadow;
  cfg_t rst_cfg;

  always_comb begin
    rst_cfg       = '0;
    rst_cfg.per   = CW'(RST_PERIOD);
    rst_cfg.syncw = SW'(RST_SYNCW);
  end

  assign clr = wr_en && (wr_addr == A_CTRL) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= rst_cfg;
      dbl    <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == A_PER)   shadow.per   <= wr_data;
      if (wr_addr == A_DT)    shadow.dt    <= wr_data[DW-1:0];
      if (wr_addr == A_SYNCW) shadow.syncw <= wr_data[SW-1:0];
      if (wr_addr == A_MODE)  dbl          <= wr_data[0];
      for (int i = 0; i < NPH; i++) begin
        if (wr_addr == AW'(int'(A_DUTY0) + i)) shadow.duty[i] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      work <= rst_cfg;
    end else if (ld) begin
      work     <= shadow;
      work.per <= (shadow.per == '0) ? CW'(1) : shadow.per;
    end
  end
endmodule

// File: rtl/cpwm_timebase.sv
module cpwm_timebase
  import cpwm_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] per,
  input  logic          dbl,
  output logic [CW-1:0] cnt,
  output logic          start,
  output logic          ld
);
  logic up;
  logic top_hit;
  logic bot_hit;

  assign top_hit = up && (cnt >= per - CW'(1));
  assign bot_hit = !up && (cnt == '0);
  assign start   = up && (cnt == '0);
  assign ld      = bot_hit || (dbl && top_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (up) begin
      if (top_hit) up <= 1'b0;
      else         cnt <= cnt + CW'(1);
    end else begin
      if (bot_hit) up <= 1'b1;
      else         cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/cpwm_phase.sv
module cpwm_phase
  import cpwm_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] per,
  input  logic [DW-1:0] dt,
  input  logic [CW-1:0] duty,
  input  logic          force_off,
  output logic          hi_n,
  output logic          lo_n
);
  localparam int PADW = CW + 1 - DW;

  logic [CW:0]   thr;
  logic [CW+1:0] lo_lim;
  logic          hi_on;
  logic          lo_on;

  always_comb begin
    thr    = (duty >= per) ? '0 : {1'b0, per - duty};
    lo_lim = {2'b00, cnt} + {{PADW{1'b0}}, dt, 1'b0};
    hi_on  = ({1'b0, cnt} >= thr);
    lo_on  = (duty == '0) ? 1'b1 : (lo_lim < {1'b0, thr});
  end

  always_ff @(posedge clk) begin
    if (rst || force_off) begin
      hi_n <= 1'b1;
      lo_n <= 1'b1;
    end else begin
      hi_n <= ~hi_on;
      lo_n <= ~lo_on;
    end
  end
endmodule

// File: rtl/cpwm_events.sv
module cpwm_events
  import cpwm_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [SW-1:0] syncw,
  input  logic          trip_i,
  input  logic          clr,
  output logic          sync_o,
  output logic          sync_irq_o,
  output logic          trip_irq_o,
  output logic          force_off
);
  logic          trip_lat;
  logic          trip_d;
  logic [SW-1:0] scnt;

  assign force_off = trip_i | trip_lat;

  always_ff @(posedge clk) begin
    if (rst) begin
      trip_lat   <= 1'b0;
      trip_d     <= 1'b0;
      trip_irq_o <= 1'b0;
      sync_o     <= 1'b0;
      sync_irq_o <= 1'b0;
      scnt       <= '0;
    end else begin
      trip_d     <= trip_i;
      trip_irq_o <= trip_i & ~trip_d;
      trip_lat   <= trip_i | (trip_lat & ~clr);
      sync_irq_o <= start;
      if (start && (syncw != '0)) begin
        sync_o <= 1'b1;
        scnt   <= syncw - SW'(1);
      end else if (scnt != '0) begin
        sync_o <= 1'b1;
        scnt   <= scnt - SW'(1);
      end else begin
        sync_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cpwm_top.sv
module cpwm_top
  import cpwm_pkg::*;
#(
  parameter int RST_PERIOD = 16,
  parameter int RST_SYNCW  = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  input  logic           trip_i,
  output logic           sync_o,
  output logic           sync_irq_o,
  output logic           trip_irq_o,
  output logic [NPH-1:0] hi_n_o,
  output logic [NPH-1:0] lo_n_o
);
  cfg_t          work;
  logic          dbl;
  logic          clr;
  logic          ld;
  logic          start;
  logic          force_off;
  logic [CW-1:0] cnt;

  cpwm_regs #(.RST_PERIOD(RST_PERIOD), .RST_SYNCW(RST_SYNCW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ld(ld), .dbl(dbl), .clr(clr), .work(work)
  );

  cpwm_timebase u_tb (
    .clk(clk), .rst(rst), .per(work.per), .dbl(dbl),
    .cnt(cnt), .start(start), .ld(ld)
  );

  cpwm_events u_ev (
    .clk(clk), .rst(rst), .start(start), .syncw(work.syncw), .trip_i(trip_i),
    .clr(clr), .sync_o(sync_o), .sync_irq_o(sync_irq_o),
    .trip_irq_o(trip_irq_o), .force_off(force_off)
  );

  for (genvar g = 0; g < NPH; g++) begin : g_ph
    cpwm_phase u_ph (
      .clk(clk), .rst(rst), .cnt(cnt), .per(work.per), .dt(work.dt),
      .duty(work.duty[g]), .force_off(force_off),
      .hi_n(hi_n_o[g]), .lo_n(lo_n_o[g])
    );
  end
endmodule

// File: rtl/cpwm_checker.sv
module cpwm_checker
  import cpwm_pkg::*;
(
  input logic           clk,
  input logic           rst,
  input logic           trip_i,
  input logic           sync_o,
  input logic           sync_irq_o,
  input logic           trip_irq_o,
  input logic [NPH-1:0] hi_n_o,
  input logic [NPH-1:0] lo_n_o
);
  p_rst_off_r7: assert property (@(posedge clk)
    rst |=> (&hi_n_o && &lo_n_o && !sync_o && !sync_irq_o && !trip_irq_o));

  p_no_overlap_r5: assert property (@(posedge clk) disable iff (rst)
    ((~hi_n_o & ~lo_n_o) == '0));

  p_trip_off_r11: assert property (@(posedge clk) disable iff (rst)
    trip_i |=> (&hi_n_o && &lo_n_o));

  p_trip_irq_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(trip_i) |=> trip_irq_o);

  p_trip_irq_once_r11: assert property (@(posedge clk) disable iff (rst)
    trip_irq_o |=> !trip_irq_o);

  p_sync_irq_once_r10: assert property (@(posedge clk) disable iff (rst)
    sync_irq_o |=> !sync_irq_o);
endmodule

bind cpwm_top cpwm_checker u_chk (
  .clk(clk), .rst(rst), .trip_i(trip_i), .sync_o(sync_o),
  .sync_irq_o(sync_irq_o), .trip_irq_o(trip_irq_o),
  .hi_n_o(hi_n_o), .lo_n_o(lo_n_o)
);

// File: tb/cpwm_top_bench.sv
module cpwm_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        trip_i = 1'b0;
  logic        sync_o, sync_irq_o, trip_irq_o;
  logic [2:0]  hi_n_o, lo_n_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int m_hi[3], m_lo[3], m_first[3];
  int m_gap, m_sync, m_irq, m_both;
  bit m_rise;

  // per, dt, duty, exp hi clocks, exp lo clocks, exp first-on index, exp gap
  localparam int NV = 7;
  localparam int VEC [NV][7] = '{
    '{20, 0,  5, 10, 30, 15,  0},
    '{20, 2,  5, 10, 22, 15,  4},
    '{20, 1,  0,  0, 40, -1, -1},
    '{20, 3, 20, 40,  0,  0, -1},
    '{20, 3, 25, 40,  0,  0, -1},
    '{10, 1,  7, 14,  2,  3,  2},
    '{ 8, 4,  1,  2,  0,  7, -1}
  };

  cpwm_top u_cpwm_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .trip_i(trip_i), .sync_o(sync_o), .sync_irq_o(sync_irq_o),
    .trip_irq_o(trip_irq_o), .hi_n_o(hi_n_o), .lo_n_o(lo_n_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en   = 1'b1;
    wr_addr = 3'(a);
    wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_sync();
    bit prev;
    do begin
      prev = sync_o;
      @(negedge clk);
    end while (!(sync_o && !prev));
  endtask

  // Caller stands on the sample where sync_o rose (index 0).
  task automatic measure(input int P, input int inj);
    int  last_hi;
    bit  last_sync;
    last_hi = -1; m_gap = -1; m_sync = 0; m_irq = 0; m_both = 0; last_sync = 1'b0;
    for (int p = 0; p < 3; p++) begin m_hi[p] = 0; m_lo[p] = 0; m_first[p] = -1; end
    for (int i = 0; i < 2 * P; i++) begin
      if (i > 0) @(negedge clk);
      for (int p = 0; p < 3; p++) begin
        if (!hi_n_o[p]) begin m_hi[p]++; if (m_first[p] < 0) m_first[p] = i; end
        if (!lo_n_o[p]) m_lo[p]++;
        if (!hi_n_o[p] && !lo_n_o[p]) m_both++;
      end
      if (!hi_n_o[0]) last_hi = i;
      if (!lo_n_o[0] && last_hi >= 0 && m_gap < 0) m_gap = i - last_hi - 1;
      if (sync_o) m_sync++;
      if (sync_irq_o) m_irq++;
      last_sync = sync_o;
      if (inj >= 0 && i == 2) begin wr_en = 1'b1; wr_addr = 3'd2; wr_data = 16'(inj); end
      if (i == 3) wr_en = 1'b0;
    end
    @(negedge clk);
    m_rise = sync_o && !last_sync;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
    end
  end

  initial begin
    // R7 reset state
    repeat (4) @(negedge clk);
    chk(hi_n_o == 3'b111 && lo_n_o == 3'b111, "R7 lines off in reset", {hi_n_o, lo_n_o}, 6'h3f);
    chk(!sync_o && !sync_irq_o && !trip_irq_o, "R7 sync/strobes low in reset", {sync_o, sync_irq_o, trip_irq_o}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(hi_n_o == 3'b111 && lo_n_o == 3'b000, "R7 R4 default duty 0", {hi_n_o, lo_n_o}, 6'h38);

    wr(5, 2);
    // Table walk: R1 R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      wait_sync();
      wr(0, VEC[v][0]);
      wr(1, VEC[v][1]);
      for (int p = 0; p < 3; p++) wr(2 + p, VEC[v][2]);
      wait_sync();
      measure(VEC[v][0], -1);
      for (int p = 0; p < 3; p++) begin
        chk(m_hi[p] == VEC[v][3], "R3 R4 high on-time", m_hi[p], VEC[v][3]);
        chk(m_lo[p] == VEC[v][4], "R5 R4 low on-time", m_lo[p], VEC[v][4]);
        chk(m_first[p] == VEC[v][5], "R3 centered first-on", m_first[p], VEC[v][5]);
      end
      chk(m_gap == VEC[v][6], (VEC[v][1] == 0) ? "R6 zero gap" : "R5 dead gap", m_gap, VEC[v][6]);
      chk(m_both == 0, "R5 no overlap", m_both, 0);
      chk(m_rise, "R2 next sync at 2P", m_rise, 1);
    end

    // R10 sync width and strobe
    wr(5, 3);
    wait_sync(); wait_sync();
    measure(8, -1);
    chk(m_sync == 3, "R10 sync width", m_sync, 3);
    chk(m_irq == 1, "R10 one sync strobe", m_irq, 1);

    // R9 double update
    wr(0, 20); wr(1, 0);
    for (int p = 0; p < 3; p++) wr(2 + p, 5);
    wr(6, 1);
    wait_sync(); wait_sync();
    measure(20, 10);
    chk(m_hi[0] == 15, "R9 mid-cycle load", m_hi[0], 15);
    chk(m_first[0] == 15, "R9 first half unchanged", m_first[0], 15);
    chk(m_hi[1] == 10, "R9 other phase unchanged", m_hi[1], 10);
    measure(20, -1);
    chk(m_hi[0] == 20 && m_first[0] == 10, "R9 next cycle", m_hi[0], 20);

    // R8 single update
    wr(6, 0); wr(2, 5);
    wait_sync(); wait_sync();
    measure(20, 10);
    chk(m_hi[0] == 10 && m_first[0] == 15, "R8 no mid-cycle load", m_hi[0], 10);
    measure(20, -1);
    chk(m_hi[0] == 20 && m_first[0] == 10, "R8 load at cycle start", m_hi[0], 20);

    // R11 trip
    for (int p = 0; p < 3; p++) wr(2 + p, 0);
    wait_sync(); wait_sync();
    repeat (3) @(negedge clk);
    chk(lo_n_o == 3'b000, "R11 pre-trip low side on", lo_n_o, 0);
    trip_i = 1'b1;
    @(negedge clk);
    chk(trip_irq_o == 1'b1, "R11 trip strobe", trip_irq_o, 1);
    chk(hi_n_o == 3'b111 && lo_n_o == 3'b111, "R11 forced off", {hi_n_o, lo_n_o}, 6'h3f);
    trip_i = 1'b0;
    @(negedge clk);
    chk(trip_irq_o == 1'b0, "R11 strobe one clock", trip_irq_o, 0);
    begin
      int bad = 0;
      repeat (45) begin
        @(negedge clk);
        if (lo_n_o != 3'b111 || hi_n_o != 3'b111) bad++;
      end
      chk(bad == 0, "R11 latched off", bad, 0);
    end
    // R12 clear ignored while trip held
    trip_i = 1'b1;
    @(negedge clk);
    wr(7, 1);
    repeat (3) @(negedge clk);
    chk(lo_n_o == 3'b111, "R12 clear ignored", lo_n_o, 7);
    trip_i = 1'b0;
    repeat (5) @(negedge clk);
    chk(lo_n_o == 3'b111, "R12 still latched", lo_n_o, 7);
    wr(7, 1);
    repeat (3) @(negedge clk);
    chk(lo_n_o == 3'b000, "R11 R1 clear resumes", lo_n_o, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule